// File: doc/BRIEF.md
# Burst Address Generator

This block produces the word address for one port of a dual-port memory. Three active-low controls act on an internal address register, and each is sampled on the rising clock edge. The address strobe loads an address supplied from outside, and that address is used for the same access. The count enable steps the register by one word per cycle, which gives burst reads or writes without a new address on every beat. The counter clear forces the address back to zero.

The controls follow a fixed priority. Clear wins over everything else. The strobe wins over counting. When no control is asserted, the register keeps its value. The counter covers the whole array (`WORDS` locations, by default every code of `ADDR_W` bits) and rolls from the last word back to zero. Besides the effective address, the block reports which source produced it, so the memory side can tell a fresh load from a burst step.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `eff_addr` = 0 and `addr_src` = 3 (zero code).
- R2: With `clear_n` high and `strobe_n` low at an edge, the next `eff_addr` equals `ext_addr` and `addr_src` = 1 (load code).
- R3: With `clear_n` and `strobe_n` high and `count_en_n` low at an edge, the next `eff_addr` is the previous value plus one and `addr_src` = 2 (increment code).
- R4: `count_en_n` has no effect on the outputs whenever `strobe_n` or `clear_n` is low at the same edge.
- R5: With `clear_n` low at an edge, the next `eff_addr` is 0 and `addr_src` = 3, whatever `strobe_n`, `count_en_n` and `ext_addr` are.
- R6: An increment from address `WORDS`-1 gives address 0. `WORDS` defaults to 2^`ADDR_W` and may be set lower.
- R7: With all three controls high at an edge, `eff_addr` keeps its value and `addr_src` = 0 (hold code).
- R8: The outputs change only at rising clock edges. Input changes between edges are not visible until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| ext_addr | input | ADDR_W | Externally supplied address |
| strobe_n | input | 1 | Active-low address load strobe |
| count_en_n | input | 1 | Active-low burst increment enable |
| clear_n | input | 1 | Active-low counter clear |
| eff_addr | output | ADDR_W | Effective address for the current access |
| addr_src | output | 2 | Source of eff_addr: 0 hold, 1 load, 2 increment, 3 zero |

## Verification
The bench starts from every address of a 4-bit configuration and applies all eight control combinations to each one. This catches a design that lets count enable leak through under a strobe or a clear: it would show an address one higher than expected. The same sweep catches a design with the wrong priority between clear and strobe, because the loaded address would appear instead of zero. Long increment runs, on the full-range counter and on a 12-word counter, check the rollover. A design that wraps at the register width instead of at `WORDS` would step to 12 instead of 0. A last test changes the controls between edges, to catch outputs that follow the inputs combinationally.

// File: rtl/burst_pkg.sv
package burst_pkg;

    // Source of the effective address; codes are visible on addr_src
    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_LOAD = 2'd1,
        SRC_INCR = 2'd2,
        SRC_ZERO = 2'd3
    } addr_src_e;

    // Controls after polarity conversion
    typedef struct packed {
        logic clr;
        logic load;
        logic step;
    } burst_ctl_t;

    // Fixed priority: clear, then load, then step, else hold
    function automatic addr_src_e pick_source(burst_ctl_t c);
        if (c.clr)       return SRC_ZERO;
        else if (c.load) return SRC_LOAD;
        else if (c.step) return SRC_INCR;
        else             return SRC_HOLD;
    endfunction

endpackage

// File: rtl/burst_ctl_decode.sv
module burst_ctl_decode
    import burst_pkg::*;
(
    input  logic      strobe_n,
    input  logic      count_en_n,
    input  logic      clear_n,
    output addr_src_e sel
);

    burst_ctl_t ctl;

    always_comb begin
        ctl.clr  = ~clear_n;
        ctl.load = ~strobe_n;
        ctl.step = ~count_en_n;
        sel      = pick_source(ctl);
    end

endmodule

// File: rtl/burst_ctr.sv
module burst_ctr
    import burst_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WORDS  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  addr_src_e         sel,
    input  logic [ADDR_W-1:0] ext,
    output logic [ADDR_W-1:0] q,
    output addr_src_e         src_q
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(WORDS - 1);
    localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);
    localparam bit FULL_RANGE = (WORDS == (1 << ADDR_W));

    logic [ADDR_W-1:0] q_inc;
    logic [ADDR_W-1:0] q_nxt;

    generate
        if (FULL_RANGE) begin : g_natural_wrap
            always_comb q_inc = q + ONE;
        end else begin : g_bounded_wrap
            always_comb q_inc = (q >= LAST) ? '0 : q + ONE;
        end
    endgenerate

    always_comb begin
        unique case (sel)
            SRC_ZERO: q_nxt = '0;
            SRC_LOAD: q_nxt = ext;
            SRC_INCR: q_nxt = q_inc;
            default:  q_nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            src_q <= SRC_ZERO;
        end else begin
            q     <= q_nxt;
            src_q <= sel;
        end
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WORDS  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              strobe_n,
    input  logic              count_en_n,
    input  logic              clear_n,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [1:0]        addr_src
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(WORDS - 1);
    localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);

    addr_src_e sel;
    addr_src_e src_q;

    burst_ctl_decode u_dec (
        .strobe_n   (strobe_n),
        .count_en_n (count_en_n),
        .clear_n    (clear_n),
        .sel        (sel)
    );

    burst_ctr #(.ADDR_W(ADDR_W), .WORDS(WORDS)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel),
        .ext   (ext_addr),
        .q     (eff_addr),
        .src_q (src_q)
    );

    assign addr_src = src_q;

    // R1
    power_on_zero_chk: assert property (@(posedge clk)
        rst |=> (eff_addr == '0 && addr_src == 2'd3));

    // R5
    clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
        !clear_n |=> (eff_addr == '0 && addr_src == 2'd3));

    // R2
    load_take_chk: assert property (@(posedge clk) disable iff (rst)
        (clear_n && !strobe_n) |=> (eff_addr == $past(ext_addr) && addr_src == 2'd1));

    // R3
    step_up_chk: assert property (@(posedge clk) disable iff (rst)
        (clear_n && strobe_n && !count_en_n && eff_addr != LAST)
            |=> (eff_addr == $past(eff_addr) + ONE && addr_src == 2'd2));

    // R6
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (clear_n && strobe_n && !count_en_n && eff_addr == LAST) |=> (eff_addr == '0));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (clear_n && strobe_n && count_en_n) |=> ($stable(eff_addr) && addr_src == 2'd0));

endmodule

// File: tb/burst_addr_gen_test.sv
module burst_addr_gen_test;

    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] ext_a, ext_b;
    logic          stb_a, cen_a, clr_a;
    logic          stb_b, cen_b, clr_b;
    logic [AW-1:0] eff_a, eff_b;
    logic [1:0]    src_a, src_b;

    int vectors = 0;
    int miscompares = 0;

    always #10 clk = ~clk;  // 50 MHz

    burst_addr_gen #(.ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .ext_addr(ext_a), .strobe_n(stb_a),
        .count_en_n(cen_a), .clear_n(clr_a), .eff_addr(eff_a), .addr_src(src_a)
    );

    burst_addr_gen #(.ADDR_W(AW), .WORDS(12)) uut_short (
        .clk(clk), .rst(rst), .ext_addr(ext_b), .strobe_n(stb_b),
        .count_en_n(cen_b), .clear_n(clr_b), .eff_addr(eff_b), .addr_src(src_b)
    );

    task automatic check(string tag, logic [AW-1:0] a, logic [1:0] s,
                         logic [AW-1:0] ea, logic [1:0] es);
        vectors++;
        if (a !== ea || s !== es) begin
            miscompares++;
            $display("FAIL %s: addr=%0d src=%0d expected addr=%0d src=%0d", tag, a, s, ea, es);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Reference model of the priority rules
    function automatic logic [AW-1:0] model_next(logic [AW-1:0] cur, logic [AW-1:0] ext,
                                                 logic stb, logic cen, logic clr, int words);
        if (!clr)      return '0;
        else if (!stb) return ext;
        else if (!cen) return (int'(cur) == words - 1) ? '0 : AW'(int'(cur) + 1);
        else           return cur;
    endfunction

    function automatic logic [1:0] model_src(logic stb, logic cen, logic clr);
        if (!clr)      return 2'd3;
        else if (!stb) return 2'd1;
        else if (!cen) return 2'd2;
        else           return 2'd0;
    endfunction

    initial begin
        #1_000_000;
        miscompares++;
        $display("FAIL watchdog: addr=%0d src=%0d expected completion", eff_a, src_a);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [AW-1:0] exp_a;
        rst = 1'b1;
        ext_a = 4'd9; stb_a = 1'b0; cen_a = 1'b0; clr_a = 1'b1;
        ext_b = 4'd0; stb_b = 1'b1; cen_b = 1'b1; clr_b = 1'b1;
        tick(); tick();
        check("R1 reset", eff_a, src_a, '0, 2'd3);
        check("R1 reset short", eff_b, src_b, '0, 2'd3);
        rst = 1'b0;

        // Exhaustive sweep: every start address x every control combination
        for (int st = 0; st < 16; st++) begin
            for (int c = 0; c < 8; c++) begin
                logic sb, ce, cl;
                logic [AW-1:0] ex;
                ext_a = AW'(st); stb_a = 1'b0; cen_a = 1'b1; clr_a = 1'b1;
                tick();
                check("R2 load", eff_a, src_a, AW'(st), 2'd1);
                sb = c[0]; ce = c[1]; cl = c[2];
                ex = AW'(st * 7 + 3);
                ext_a = ex; stb_a = sb; cen_a = ce; clr_a = cl;
                tick();
                exp_a = model_next(AW'(st), ex, sb, ce, cl, 16);
                if (!cl)       check("R5 clear priority", eff_a, src_a, exp_a, model_src(sb, ce, cl));
                else if (!sb)  check("R4 strobe masks count", eff_a, src_a, exp_a, model_src(sb, ce, cl));
                else if (!ce)  check("R3 increment / R6 wrap", eff_a, src_a, exp_a, model_src(sb, ce, cl));
                else           check("R7 hold", eff_a, src_a, exp_a, model_src(sb, ce, cl));
            end
        end

        // Long burst through the full-range rollover
        ext_a = 4'd13; stb_a = 1'b0; cen_a = 1'b1; clr_a = 1'b1;
        tick();
        stb_a = 1'b1; cen_a = 1'b0;
        exp_a = 4'd13;
        for (int i = 0; i < 20; i++) begin
            tick();
            exp_a = AW'(int'(exp_a) + 1);
            check("R6 full wrap burst", eff_a, src_a, exp_a, 2'd2);
        end

        // Short counter: wraps at WORDS-1 = 11
        ext_b = 4'd9; stb_b = 1'b0; cen_b = 1'b1; clr_b = 1'b1;
        tick();
        check("R2 load short", eff_b, src_b, 4'd9, 2'd1);
        stb_b = 1'b1; cen_b = 1'b0;
        exp_a = 4'd9;
        for (int i = 0; i < 16; i++) begin
            tick();
            exp_a = (exp_a == 4'd11) ? 4'd0 : exp_a + 4'd1;
            check("R6 short wrap", eff_b, src_b, exp_a, 2'd2);
        end

        // Clear with strobe and count both active on the short counter
        stb_b = 1'b0; cen_b = 1'b0; clr_b = 1'b0; ext_b = 4'd7;
        tick();
        check("R5 clear over strobe", eff_b, src_b, 4'd0, 2'd3);

        // Between-edge changes are not visible until the next edge
        ext_a = 4'd5; stb_a = 1'b0; cen_a = 1'b1; clr_a = 1'b1;
        tick();
        check("R8 load seen", eff_a, src_a, 4'd5, 2'd1);
        clr_a = 1'b0; ext_a = 4'd2;
        #5;
        check("R8 no mid-cycle change", eff_a, src_a, 4'd5, 2'd1);
        clr_a = 1'b1; stb_a = 1'b1; cen_a = 1'b1;
        tick();
        check("R8 R7 hold after glitch", eff_a, src_a, 4'd5, 2'd0);

        // Synchronous reset in the middle of a burst
        cen_a = 1'b0;
        tick();
        rst = 1'b1;
        tick();
        check("R1 mid-burst reset", eff_a, src_a, 4'd0, 2'd3);
        rst = 1'b0; cen_a = 1'b1;
        tick();
        check("R7 hold after reset", eff_a, src_a, 4'd0, 2'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule